// File: doc/BRIEF.md
# ARINC 429 FIFO Transmitter with Word Gap Timer

This block turns words written by a host into a bipolar return-to-zero serial stream of the kind used on ARINC 429 avionics buses. The host writes each 31-bit word as two 16-bit halves with two load strobes, and the assembled word goes into an eight-entry FIFO. While the transmit enable is high, the block takes words from the FIFO one after another. It sends either 24 or 31 data bits, least significant bit first, followed by a parity bit that it generates. Between consecutive words it holds the line at null for four bit times.

A bit-rate clock output runs at the selected transmit rate, which is either the system clock divided by 10 or divided by 80. A ready flag tells the host that the FIFO has drained. The word length, the rate and the parity sense are plain input ports. The line driver and any shared-bus tristate are outside the block.

Top module: `a429_serial_tx`

## Requirements
- R1: A rising edge on `load_lo` stores `host_data[15:0]` as word bits 15:0, and a later rising edge replaces that half. A rising edge on `load_hi` takes `host_data[14:0]` as word bits 30:16 and pushes the assembled word into the FIFO. `host_data[15]` is ignored during the second half.
- R2: The FIFO holds up to 8 words and sends them in the order they were loaded. A push while it holds 8 words is discarded.
- R3: Load strobes have no effect while `tx_en` is high.
- R4: The data bits go out least significant first. A 1 drives `line_a` high for the first half of the bit time, and a 0 drives `line_b` high for the first half. Both lines are low in the second half and whenever no bit is being sent, and they are never high together.
- R5: With `len_short`=0 a word is 31 data bits plus parity (32 pulses). With `len_short`=1 it is bits 23:0 plus parity (25 pulses).
- R6: The parity bit makes the count of ones over the data bits and parity odd when `parity_even`=0, and even when `parity_even`=1.
- R7: While `tx_en` stays high and words remain, the next word begins exactly 4 bit times after the last bit time of the previous word ends.
- R8: The bit time is 10 clocks when `rate_slow`=0 and 80 clocks when `rate_slow`=1. Line pulses last half a bit time. `bit_clk` is high for the first half of each bit time and low for the second half.
- R9: `tx_ready` is high when the FIFO is empty and no data bit is being sent. It is low while words are stored.
- R10: When `tx_en` falls during a word, both lines are null from the next cycle on. That word is dropped and is not resumed.
- R11: `rst` empties the FIFO and stops the transmitter. After reset both lines are null and `tx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_data | input | 16 | Half-word from the host |
| load_lo | input | 1 | Load strobe for bits 15:0 |
| load_hi | input | 1 | Load strobe for bits 30:16; pushes the word |
| tx_en | input | 1 | Transmit enable; loads are accepted only while low |
| len_short | input | 1 | 1 selects 24 data bits, 0 selects 31 |
| rate_slow | input | 1 | 1 selects clock/80, 0 selects clock/10 |
| parity_even | input | 1 | 1 selects even parity, 0 selects odd |
| line_a | output | 1 | Positive rail; pulses for a 1 bit |
| line_b | output | 1 | Negative rail; pulses for a 0 bit |
| bit_clk | output | 1 | Clock at the transmit bit rate |
| tx_ready | output | 1 | FIFO drained and no bit in flight |

## Verification
The main path runs over all eight combinations of word length, rate and parity sense, with three distinct words in each. A decoded word shows whether the length is right, whether the bit order is right and whether the parity sense is right. The measured null between words separates a 4-bit gap from an off-by-one gap, and the pulse widths tell the two rates apart. Further patterns fill the FIFO with one word too many, overwrite the low half, strobe loads while enabled, drop the enable mid-word and reset with words stored. Each of these separates discarding from storing, and aborting from resuming.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;

    localparam int unsigned DEF_WORD_W     = 31;
    localparam int unsigned DEF_HALF_W     = 16;
    localparam int unsigned DEF_DEPTH      = 8;
    localparam int unsigned DEF_SHORT_BITS = 24;
    localparam int unsigned DEF_GAP_BITS   = 4;
    localparam int unsigned DEF_FAST_DIV   = 10;
    localparam int unsigned DEF_SLOW_DIV   = 80;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_GAP  = 2'd2
    } tx_state_e;

    // Parity bit from the XOR of the data bits and the selected sense.
    function automatic logic parity_bit(input logic data_xor, input logic even_sel);
        return data_xor ^ ~even_sel;
    endfunction

endpackage

// File: rtl/a429_tx_stage.sv
module a429_tx_stage #(
    parameter int unsigned HALF_W = 16,
    parameter int unsigned WORD_W = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              load_lo,
    input  logic              load_hi,
    input  logic [HALF_W-1:0] host_data,
    output logic              push,
    output logic [WORD_W-1:0] push_word
);
    localparam int unsigned UPPER_W = WORD_W - HALF_W;

    logic              lo_d, hi_d;
    logic [HALF_W-1:0] lo_q;
    logic              lo_rise, hi_rise;

    assign lo_rise = load_lo && !lo_d;
    assign hi_rise = load_hi && !hi_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_d <= 1'b0;
            hi_d <= 1'b0;
            lo_q <= '0;
        end else begin
            lo_d <= load_lo;
            hi_d <= load_hi;
            if (lo_rise && !tx_en) lo_q <= host_data;
        end
    end

    assign push      = hi_rise && !tx_en;
    assign push_word = {host_data[UPPER_W-1:0], lo_q};

endmodule

// File: rtl/a429_tx_fifo.sv
module a429_tx_fifo #(
    parameter int unsigned WORD_W = 31,
    parameter int unsigned DEPTH  = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [WORD_W-1:0]          wdata,
    input  logic                       pop,
    output logic [WORD_W-1:0]          rdata,
    output logic                       empty,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  cnt_q;
    logic              do_push, do_pop;

    assign do_push = push && (cnt_q != CNT_FULL);
    assign do_pop  = pop && (cnt_q != '0);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (do_push && (wr_ptr == PTR_W'(g))) mem[g] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign rdata = mem[rd_ptr];
    assign empty = (cnt_q == '0);
    assign count = cnt_q;

endmodule

// File: rtl/a429_tx_baud.sv
module a429_tx_baud #(
    parameter int unsigned FAST_DIV = 10,
    parameter int unsigned SLOW_DIV = 80
) (
    input  logic clk,
    input  logic rst,
    input  logic rate_slow,
    output logic tick,
    output logic first_half
);
    localparam int unsigned MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
    localparam int unsigned CNT_W   = $clog2(MAX_DIV);
    localparam logic [CNT_W-1:0] FAST_LIM  = CNT_W'(FAST_DIV - 1);
    localparam logic [CNT_W-1:0] SLOW_LIM  = CNT_W'(SLOW_DIV - 1);
    localparam logic [CNT_W-1:0] FAST_HALF = CNT_W'(FAST_DIV / 2);
    localparam logic [CNT_W-1:0] SLOW_HALF = CNT_W'(SLOW_DIV / 2);

    logic [CNT_W-1:0] cnt_q, lim, half;

    assign lim        = rate_slow ? SLOW_LIM : FAST_LIM;
    assign half       = rate_slow ? SLOW_HALF : FAST_HALF;
    assign tick       = (cnt_q >= lim);
    assign first_half = (cnt_q < half);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/a429_tx_shift.sv
module a429_tx_shift
    import a429_tx_pkg::*;
#(
    parameter int unsigned WORD_W     = 31,
    parameter int unsigned SHORT_BITS = 24,
    parameter int unsigned GAP_BITS   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              first_half,
    input  logic              tx_en,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_word,
    input  logic              len_short,
    input  logic              parity_even,
    output logic              pop,
    output logic              line_a,
    output logic              line_b,
    output logic              in_data
);
    localparam int unsigned IDX_W = $clog2(WORD_W + 1);
    localparam int unsigned GAP_W = $clog2(GAP_BITS + 1);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_BITS - 1);
    localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(WORD_W);
    localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(SHORT_BITS);

    tx_state_e         state_q;
    logic [WORD_W:0]   sr_q;
    logic [IDX_W-1:0]  idx_q, last_q;
    logic [GAP_W-1:0]  gap_q;
    logic              start;

    // Data bits kept up to the selected length, parity placed just above them.
    function automatic logic [WORD_W:0] make_frame(input logic [WORD_W-1:0] w,
                                                   input logic short_sel,
                                                   input logic even_sel);
        logic [WORD_W:0] f;
        logic            x;
        int              n;
        n = short_sel ? int'(SHORT_BITS) : int'(WORD_W);
        f = '0;
        x = 1'b0;
        for (int i = 0; i < int'(WORD_W); i++) begin
            if (i < n) begin
                f[i] = w[i];
                x    = x ^ w[i];
            end
        end
        f[n] = parity_bit(x, even_sel);
        return f;
    endfunction

    assign start = tx_en && tick && !fifo_empty &&
                   ((state_q == ST_IDLE) || ((state_q == ST_GAP) && (gap_q == GAP_LAST)));
    assign pop   = start;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            sr_q    <= '0;
            idx_q   <= '0;
            last_q  <= '0;
            gap_q   <= '0;
        end else if (!tx_en) begin
            state_q <= ST_IDLE;
        end else if (tick) begin
            if (start) begin
                state_q <= ST_DATA;
                sr_q    <= make_frame(fifo_word, len_short, parity_even);
                idx_q   <= '0;
                last_q  <= len_short ? LAST_SHORT : LAST_LONG;
            end else begin
                case (state_q)
                    ST_DATA: begin
                        if (idx_q == last_q) begin
                            state_q <= ST_GAP;
                            gap_q   <= '0;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                            sr_q  <= sr_q >> 1;
                        end
                    end
                    ST_GAP: begin
                        if (gap_q == GAP_LAST) state_q <= ST_IDLE;
                        else                   gap_q   <= gap_q + 1'b1;
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign in_data = (state_q == ST_DATA);
    assign line_a  = in_data && first_half && sr_q[0];
    assign line_b  = in_data && first_half && !sr_q[0];

endmodule

// File: rtl/a429_serial_tx.sv
module a429_serial_tx
    import a429_tx_pkg::*;
#(
    parameter int unsigned WORD_W     = DEF_WORD_W,
    parameter int unsigned HALF_W     = DEF_HALF_W,
    parameter int unsigned DEPTH      = DEF_DEPTH,
    parameter int unsigned SHORT_BITS = DEF_SHORT_BITS,
    parameter int unsigned GAP_BITS   = DEF_GAP_BITS,
    parameter int unsigned FAST_DIV   = DEF_FAST_DIV,
    parameter int unsigned SLOW_DIV   = DEF_SLOW_DIV
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HALF_W-1:0] host_data,
    input  logic              load_lo,
    input  logic              load_hi,
    input  logic              tx_en,
    input  logic              len_short,
    input  logic              rate_slow,
    input  logic              parity_even,
    output logic              line_a,
    output logic              line_b,
    output logic              bit_clk,
    output logic              tx_ready
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic              push, pop, fifo_empty, tick, first_half, in_data;
    logic [WORD_W-1:0] push_word, fifo_word;
    logic [CNT_W-1:0]  fifo_cnt;

    a429_tx_stage #(.HALF_W(HALF_W), .WORD_W(WORD_W)) u_stage (
        .clk(clk), .rst(rst), .tx_en(tx_en),
        .load_lo(load_lo), .load_hi(load_hi), .host_data(host_data),
        .push(push), .push_word(push_word)
    );

    a429_tx_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(push), .wdata(push_word),
        .pop(pop), .rdata(fifo_word), .empty(fifo_empty), .count(fifo_cnt)
    );

    a429_tx_baud #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_baud (
        .clk(clk), .rst(rst), .rate_slow(rate_slow),
        .tick(tick), .first_half(first_half)
    );

    a429_tx_shift #(.WORD_W(WORD_W), .SHORT_BITS(SHORT_BITS), .GAP_BITS(GAP_BITS)) u_shift (
        .clk(clk), .rst(rst), .tick(tick), .first_half(first_half),
        .tx_en(tx_en), .fifo_empty(fifo_empty), .fifo_word(fifo_word),
        .len_short(len_short), .parity_even(parity_even),
        .pop(pop), .line_a(line_a), .line_b(line_b), .in_data(in_data)
    );

    assign bit_clk  = first_half;
    assign tx_ready = fifo_empty && !in_data;

endmodule

// File: rtl/a429_tx_chk.sv
module a429_tx_chk #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             tx_en,
    input logic             line_a,
    input logic             line_b,
    input logic             tx_ready,
    input logic [CNT_W-1:0] fifo_cnt
);
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        fifo_cnt <= CNT_W'(DEPTH));

    assert_load_gated_R3: assert property (@(posedge clk) disable iff (rst)
        tx_en |=> (fifo_cnt <= $past(fifo_cnt)));

    assert_lines_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(line_a && line_b));

    assert_ready_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> (!line_a && !line_b));

    assert_abort_null_R10: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> (!line_a && !line_b));

    assert_reset_clear_R11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (fifo_cnt == '0 && tx_ready));
endmodule

bind a429_serial_tx a429_tx_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .tx_en(tx_en), .line_a(line_a), .line_b(line_b),
    .tx_ready(tx_ready), .fifo_cnt(fifo_cnt)
);

// File: tb/a429_serial_tx_tb.sv
`timescale 1ns/1ps
module a429_serial_tx_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] host_data = '0;
    logic        load_lo = 1'b0, load_hi = 1'b0, tx_en = 1'b0;
    logic        len_short = 1'b0, rate_slow = 1'b0, parity_even = 1'b0;
    logic        line_a, line_b, bit_clk, tx_ready;

    always #2.5 clk = ~clk;

    a429_serial_tx u_dut (
        .clk(clk), .rst(rst), .host_data(host_data), .load_lo(load_lo),
        .load_hi(load_hi), .tx_en(tx_en), .len_short(len_short),
        .rate_slow(rate_slow), .parity_even(parity_even), .line_a(line_a),
        .line_b(line_b), .bit_clk(bit_clk), .tx_ready(tx_ready)
    );

    int checks = 0, fails = 0;
    bit done = 1'b0;
    int per = 10;

    // Line decoder
    logic [31:0] rx_word [0:127];
    int          rx_len  [0:127];
    int          rx_gap  [0:127];
    int          rx_cnt = 0;
    logic [31:0] cur_word = '0;
    int          cur_len = 0, cur_gap = 0, null_run = 1000, hi_run = 0, bc_run = 0;
    int          pw_bad = 0, bc_bad = 0;
    logic        prev_on = 1'b0, prev_bc = 1'b0;

    always @(negedge clk) begin
        logic on;
        on = line_a | line_b;
        if (on) begin
            if (!prev_on) begin
                if (cur_len == 0) begin
                    cur_gap  = null_run;
                    cur_word = '0;
                end
                if (cur_len < 32) cur_word[cur_len] = line_a;
                cur_len++;
            end
            hi_run++;
            null_run = 0;
        end else begin
            if (prev_on) begin
                if (hi_run != per / 2) pw_bad++;
                hi_run = 0;
            end
            if (null_run < 100000) null_run++;
            if (cur_len > 0 && null_run == 2 * per) begin
                if (rx_cnt < 128) begin
                    rx_word[rx_cnt] = cur_word;
                    rx_len[rx_cnt]  = cur_len;
                    rx_gap[rx_cnt]  = cur_gap;
                    rx_cnt++;
                end
                cur_len = 0;
            end
        end
        prev_on = on;
        if (bit_clk) bc_run++;
        else if (prev_bc) begin
            if (bc_run != per / 2) bc_bad++;
            bc_run = 0;
        end
        prev_bc = bit_clk;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_lo(input logic [15:0] v);
        host_data = v; load_lo = 1'b1; cyc(1);
        load_lo = 1'b0; cyc(1);
    endtask

    // Second half drives bit 15 high to show it is ignored (R1).
    task automatic load_word(input logic [30:0] w);
        pulse_lo(w[15:0]);
        host_data = {1'b1, w[30:16]}; load_hi = 1'b1; cyc(1);
        load_hi = 1'b0; cyc(1);
    endtask

    task automatic set_cfg(input bit s, input bit r, input bit e);
        len_short = s; rate_slow = r; parity_even = e;
        per = r ? 80 : 10;
        cyc(200);
        pw_bad = 0; bc_bad = 0;
    endtask

    task automatic wait_rx(input int target);
        for (int i = 0; i < 20000 && rx_cnt < target; i++) cyc(1);
    endtask

    function automatic logic [31:0] exp_frame(input logic [30:0] w, input bit s, input bit e);
        logic [31:0] f;
        logic        x;
        int          n;
        n = s ? 24 : 31;
        f = '0; x = 1'b0;
        for (int i = 0; i < n; i++) begin
            f[i] = w[i];
            x    = x ^ w[i];
        end
        f[n] = e ? x : ~x;
        return f;
    endfunction

    function automatic logic [30:0] make_w(input int a, input int b);
        logic [31:0] t;
        t = 32'h5A3C_96E1 ^ (32'(a) * 32'h1357_9BDF) ^ (32'(b) * 32'h0F0F_3333);
        return t[30:0];
    endfunction

    task automatic check_word(input int idx, input logic [30:0] w, input bit s,
                              input bit e, input bit check_gap);
        logic [31:0] ef, mask;
        int          n;
        n    = s ? 24 : 31;
        ef   = exp_frame(w, s, e);
        mask = (32'd1 << n) - 32'd1;
        chk(rx_len[idx] == n + 1, "R5", "pulses per word", 32'(rx_len[idx]), 32'(n + 1));
        chk((rx_word[idx] & mask) == (ef & mask), "R4/R1", "data bits",
            rx_word[idx] & mask, ef & mask);
        chk(rx_word[idx][n] == ef[n], "R6", "parity bit", 32'(rx_word[idx][n]), 32'(ef[n]));
        if (check_gap)
            chk(rx_gap[idx] == per * 9 / 2, "R7", "null clocks between words",
                32'(rx_gap[idx]), 32'(per * 9 / 2));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int base;
        logic [30:0] ws [0:8];
        cyc(3);
        // R11: state while in reset
        chk(!line_a && !line_b, "R11", "lines in reset", {30'd0, line_a, line_b}, 32'd0);
        chk(tx_ready == 1'b1, "R11", "ready in reset", 32'(tx_ready), 32'd1);
        rst = 1'b0;
        cyc(2);

        // Sweep all length / rate / parity combinations
        for (int cfg = 0; cfg < 8; cfg++) begin
            bit s, r, e;
            s = cfg[0]; r = cfg[1]; e = cfg[2];
            set_cfg(s, r, e);
            base = rx_cnt;
            for (int k = 0; k < 3; k++) begin
                ws[k] = make_w(cfg, k);
                load_word(ws[k]);
            end
            chk(tx_ready == 1'b0, "R9", "ready with words stored", 32'(tx_ready), 32'd0);
            tx_en = 1'b1;
            wait_rx(base + 3);
            chk(rx_cnt == base + 3, "R2", "words sent", 32'(rx_cnt - base), 32'd3);
            for (int k = 0; k < 3; k++) check_word(base + k, ws[k], s, e, k > 0);
            chk(pw_bad == 0, "R8", "line pulse width errors", 32'(pw_bad), 32'd0);
            chk(bc_bad == 0, "R8", "bit_clk high width errors", 32'(bc_bad), 32'd0);
            chk(tx_ready == 1'b1, "R9", "ready after drain", 32'(tx_ready), 32'd1);
            tx_en = 1'b0;
            cyc(4);
        end

        // R1: low half overwritten before the push
        set_cfg(1'b0, 1'b0, 1'b0);
        base = rx_cnt;
        ws[0] = make_w(11, 5);
        pulse_lo(16'hFFFF);
        load_word(ws[0]);
        tx_en = 1'b1;
        wait_rx(base + 1);
        check_word(base, ws[0], 1'b0, 1'b0, 1'b0);
        tx_en = 1'b0;
        cyc(4);

        // R2: nine loads, only the first eight are kept, in order
        base = rx_cnt;
        for (int k = 0; k < 9; k++) begin
            ws[k] = make_w(20 + k, k);
            load_word(ws[k]);
        end
        tx_en = 1'b1;
        wait_rx(base + 8);
        cyc(50 * per);
        chk(rx_cnt == base + 8, "R2", "words after overfill", 32'(rx_cnt - base), 32'd8);
        for (int k = 0; k < 8; k++) check_word(base + k, ws[k], 1'b0, 1'b0, k > 0);
        tx_en = 1'b0;
        cyc(4);

        // R3: loads while enabled have no effect
        base = rx_cnt;
        tx_en = 1'b1;
        cyc(2);
        load_word(make_w(40, 1));
        cyc(60 * per);
        chk(rx_cnt == base, "R3", "words after enabled load", 32'(rx_cnt - base), 32'd0);
        tx_en = 1'b0;
        cyc(2);
        chk(tx_ready == 1'b1, "R3", "FIFO empty after enabled load", 32'(tx_ready), 32'd1);

        // R10: abort mid-word
        base = rx_cnt;
        load_word(make_w(41, 2));
        tx_en = 1'b1;
        for (int i = 0; i < 2000 && cur_len < 5; i++) cyc(1);
        tx_en = 1'b0;
        cyc(1);
        begin
            int seen;
            seen = 0;
            for (int i = 0; i < 3 * per; i++) begin
                if (line_a || line_b) seen++;
                cyc(1);
            end
            chk(seen == 0, "R10", "line activity after abort", 32'(seen), 32'd0);
        end
        chk(tx_ready == 1'b1, "R10", "ready after abort", 32'(tx_ready), 32'd1);
        chk(rx_cnt == base + 1 && rx_len[base] < 32, "R10", "partial word length",
            32'(rx_len[base]), 32'd31);
        tx_en = 1'b1;
        cyc(60 * per);
        chk(rx_cnt == base + 1, "R10", "words after re-enable", 32'(rx_cnt - base), 32'd1);
        tx_en = 1'b0;
        cyc(4);

        // R11: reset discards stored words
        base = rx_cnt;
        load_word(make_w(50, 3));
        load_word(make_w(51, 4));
        chk(tx_ready == 1'b0, "R9", "ready before reset", 32'(tx_ready), 32'd0);
        rst = 1'b1;
        cyc(2);
        rst = 1'b0;
        cyc(1);
        chk(tx_ready == 1'b1, "R11", "ready after reset", 32'(tx_ready), 32'd1);
        tx_en = 1'b1;
        cyc(60 * per);
        chk(rx_cnt == base, "R11", "words after reset", 32'(rx_cnt - base), 32'd0);
        tx_en = 1'b0;
        cyc(4);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule